// File: doc/BRIEF.md
# DMA Request Routing Multiplexer

This block sits between a large set of peripheral DMA request lines and a smaller bank of DMA channel request inputs on the DMA engine. Each output channel owns one configuration byte that names a source number, an enable bit and, on the lowest channels, a trigger-enable bit. An enabled channel forwards the level of its chosen source to the engine one clock later. Source number 0 and the unassigned numbers turn a channel off. The six numbers at the top of the source range are requestors that are always asserted, for memory-to-memory style transfers.

The lowest `NUM_TRIG` channels (default four) can also be paced by a timer. Channel n pairs with timer pulse input n. In paced mode, a timer pulse that arrives while the selected source is asserted arms a single request. That request is held until the engine acknowledges it on the channel's `ch_ack` line, and the channel then waits for the next pulse. This gives transfers at fixed intervals with no processor work. Configuration is meant to be written at boot. It may be changed at run time by disabling the channel, changing the source and enabling the channel again.

All pins are plain control levels with no valid/ready handshake. A channel request is a level that the engine takes when it is able. There is no back-pressure: a request that the engine has not yet served simply stays high while its source (and, in paced mode, its armed state) holds. Software should keep the enabled channels on distinct peripheral sources. If two enabled channels pick the same peripheral source, only the lower-numbered channel sees that source.

Top module: `dma_req_router`

## Requirements
- R1: After reset every channel byte reads 0x00, every channel request is low, and the read data is 0x00.
- R2: A write stores one byte per channel with enable at bit 7, trigger-enable at bit 6 and the source number at bits 5:0. The byte of the channel named on `cfg_rd_ch` appears on `cfg_rdata` after the next clock edge, and this value already includes a write made at that same edge.
- R3: On channels at or above `NUM_TRIG`, the trigger-enable bit is not stored. It reads as 0, and such a channel routes its source as if the bit had never been written.
- R4: An enabled, unpaced channel whose source number s is in 1..`PERIPH_N` (default 40) drives `periph_req[s-1]` onto its `ch_req` bit one clock later.
- R5: Source number 0, and the unassigned numbers `PERIPH_N`+1..57, never produce a request, even while every peripheral line is high.
- R6: Source numbers 58..63 give a request that stays high for as long as the unpaced channel stays enabled. It rises at the clock edge that stores the enabling write.
- R7: A channel with its enable bit clear never requests. A write that clears the enable bit drops the request at the same clock edge that stores the write.
- R8: A paced channel arms when its timer pulse is high while its source is high. It then requests from the next clock onward until a clock edge at which its `ch_ack` bit is high. After that edge the request is low, and it stays low until the next pulse.
- R9: A paced channel whose source is high but which receives no timer pulse never requests.
- R10: Clearing the enable bit of a paced channel discards its armed request. Enabling the channel again gives no request until a fresh pulse arrives.
- R11: When two enabled channels select the same peripheral source, only the lower-numbered channel passes it. Once the lower channel is disabled, the higher channel receives the source at the edge that stores that write.
- R12: Timer pulse n arms only channel n. It has no effect on the other paced channels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Write strobe for a channel byte |
| cfg_wr_ch | input | CH_W | Channel addressed by the write |
| cfg_wdata | input | 8 | Byte written: bit 7 enable, bit 6 trigger-enable, bits 5:0 source number |
| cfg_rd_ch | input | CH_W | Channel whose byte is returned |
| cfg_rdata | output | 8 | Registered read data |
| periph_req | input | PERIPH_N | Peripheral request lines; bit s-1 is source s |
| trig_pulse | input | NUM_TRIG | Timer pulses; bit n paces channel n |
| ch_ack | input | NUM_CH | Acknowledge from the DMA engine, one bit per channel |
| ch_req | output | NUM_CH | Registered request, one bit per channel |

## Verification
Every result is due exactly one clock edge after its cause. A peripheral level, a timer pulse or an acknowledge that is driven before edge k shows on `ch_req` after edge k. A configuration write takes effect on `ch_req` and `cfg_rdata` at the same edge that stores it. The bench drives all inputs on the falling edge and samples on the following falling edge, half a period after the edge that should produce the change. One check samples before that edge to confirm that the output has not yet moved. Held states, such as an armed request awaiting acknowledge or a channel waiting for a pulse, are sampled across several further cycles.

// File: rtl/dmr_pkg.sv
package dmr_pkg;
  localparam int SRC_W = 6;

  // byte layout: [7] enable, [6] trigger-enable, [5:0] source number
  typedef struct packed {
    logic             en;
    logic             trig;
    logic [SRC_W-1:0] src;
  } chan_cfg_t;
endpackage

// File: rtl/dmr_cfg_regs.sv
module dmr_cfg_regs
  import dmr_pkg::*;
#(
  parameter int NUM_CH   = 16,
  parameter int NUM_TRIG = 4,
  parameter int CH_W     = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [CH_W-1:0]        wr_ch,
  input  logic [7:0]             wr_data,
  input  logic [CH_W-1:0]        rd_ch,
  output logic [7:0]             rd_data,
  output chan_cfg_t [NUM_CH-1:0] cfg_nxt,
  output chan_cfg_t [NUM_CH-1:0] cfg_q
);

  always_comb begin
    for (int i = 0; i < NUM_CH; i++) begin
      cfg_nxt[i] = cfg_q[i];
      if (wr_en && wr_ch == CH_W'(i)) begin
        cfg_nxt[i] = chan_cfg_t'(wr_data);
        if (i >= NUM_TRIG) cfg_nxt[i].trig = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q   <= '0;
      rd_data <= '0;
    end else begin
      cfg_q   <= cfg_nxt;
      rd_data <= (int'(rd_ch) < NUM_CH) ? cfg_nxt[rd_ch] : 8'h00;
    end
  end

  genvar g;
  generate
    for (g = NUM_TRIG; g < NUM_CH; g++) begin : g_chk
      // R3: unpaced channels never hold a trigger-enable bit
      a_r3_trig_bit_absent: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_q[g].trig);
    end
  endgenerate

endmodule

// File: rtl/dmr_src_select.sv
module dmr_src_select
  import dmr_pkg::*;
#(
  parameter int NUM_CH    = 16,
  parameter int PERIPH_N  = 40,
  parameter int ALWAYS_LO = 58
) (
  input  chan_cfg_t [NUM_CH-1:0] cfg,
  input  logic [PERIPH_N-1:0]    periph_req,
  output logic [NUM_CH-1:0]      hit
);

  localparam int SRC_N = 2 ** SRC_W;

  logic [SRC_N-1:0] req_pad;
  assign req_pad = SRC_N'(periph_req);

  genvar i;
  generate
    for (i = 0; i < NUM_CH; i++) begin : g_ch
      logic             is_periph;
      logic             is_always;
      logic             raw;
      logic             blocked;
      logic [SRC_W-1:0] idx;

      always_comb begin
        is_periph = (cfg[i].src != '0) && (int'(cfg[i].src) <= PERIPH_N);
        is_always = int'(cfg[i].src) >= ALWAYS_LO;
        idx       = cfg[i].src - SRC_W'(1);
        raw       = is_always | (is_periph & req_pad[idx]);
        blocked   = 1'b0;
        // a lower enabled channel on the same peripheral source takes it
        for (int j = 0; j < i; j++) begin
          if (cfg[j].en && cfg[j].src == cfg[i].src && is_periph) blocked = 1'b1;
        end
      end

      assign hit[i] = raw & ~blocked;
    end
  endgenerate

endmodule

// File: rtl/dmr_chan_gate.sv
module dmr_chan_gate #(
  parameter bit TRIG_CAP = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_n,
  input  logic trig_n,
  input  logic hit,
  input  logic pulse,
  input  logic ack,
  output logic req_q
);

  logic req_d;

  generate
    if (TRIG_CAP) begin : g_paced
      logic armed_q;
      logic armed_d;

      always_comb begin
        armed_d = en_n & trig_n & ((armed_q & ~ack) | (pulse & hit));
        req_d   = trig_n ? (armed_d & hit) : (en_n & hit);
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed_q <= 1'b0;
        else        armed_q <= armed_d;
      end

      // R8: an armed request is kept until acknowledged
      a_r8_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && !ack && en_n && trig_n) |=> armed_q);
      // R10: disabling throws away a pending paced request
      a_r10_disable_discards: assert property (@(posedge clk) disable iff (!rst_n)
        !en_n |=> !armed_q);
    end else begin : g_plain
      logic unused_inputs;
      assign unused_inputs = ^{trig_n, pulse, ack};
      assign req_d = en_n & hit;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= 1'b0;
    else        req_q <= req_d;
  end

endmodule

// File: rtl/dma_req_router.sv
module dma_req_router
  import dmr_pkg::*;
#(
  parameter int NUM_CH    = 16,
  parameter int NUM_TRIG  = 4,
  parameter int PERIPH_N  = 40,
  parameter int ALWAYS_LO = 58,
  parameter int CH_W      = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  logic [CH_W-1:0]     cfg_wr_ch,
  input  logic [7:0]          cfg_wdata,
  input  logic [CH_W-1:0]     cfg_rd_ch,
  output logic [7:0]          cfg_rdata,
  input  logic [PERIPH_N-1:0] periph_req,
  input  logic [NUM_TRIG-1:0] trig_pulse,
  input  logic [NUM_CH-1:0]   ch_ack,
  output logic [NUM_CH-1:0]   ch_req
);

  chan_cfg_t [NUM_CH-1:0] cfg_nxt;
  chan_cfg_t [NUM_CH-1:0] cfg_q;
  logic      [NUM_CH-1:0] hit;

  dmr_cfg_regs #(
    .NUM_CH(NUM_CH), .NUM_TRIG(NUM_TRIG), .CH_W(CH_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en(cfg_we), .wr_ch(cfg_wr_ch), .wr_data(cfg_wdata),
    .rd_ch(cfg_rd_ch), .rd_data(cfg_rdata),
    .cfg_nxt(cfg_nxt), .cfg_q(cfg_q)
  );

  // selection uses the post-write configuration so enable changes act at the write edge
  dmr_src_select #(
    .NUM_CH(NUM_CH), .PERIPH_N(PERIPH_N), .ALWAYS_LO(ALWAYS_LO)
  ) u_sel (
    .cfg(cfg_nxt), .periph_req(periph_req), .hit(hit)
  );

  genvar i;
  generate
    for (i = 0; i < NUM_CH; i++) begin : g_ch
      logic pulse_i;
      if (i < NUM_TRIG) begin : g_tp
        assign pulse_i = trig_pulse[i];
      end else begin : g_np
        assign pulse_i = 1'b0;
      end

      dmr_chan_gate #(.TRIG_CAP(i < NUM_TRIG)) u_gate (
        .clk(clk), .rst_n(rst_n),
        .en_n(cfg_nxt[i].en), .trig_n(cfg_nxt[i].trig),
        .hit(hit[i]), .pulse(pulse_i), .ack(ch_ack[i]),
        .req_q(ch_req[i])
      );

      // R7: a disabled channel is silent
      a_r7_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_q[i].en |-> !ch_req[i]);
      // R5: source 0 and unassigned numbers never request
      a_r5_dead_source: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q[i].src == '0 ||
         (int'(cfg_q[i].src) > PERIPH_N && int'(cfg_q[i].src) < ALWAYS_LO))
        |-> !ch_req[i]);
      // R6: always-on numbers request continuously on an enabled unpaced channel
      a_r6_always_on: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q[i].en && !cfg_q[i].trig && int'(cfg_q[i].src) >= ALWAYS_LO)
        |-> ch_req[i]);
    end
  endgenerate

endmodule

// File: tb/tb_dma_req_router.sv
`timescale 1ns/1ps
module tb_dma_req_router;
  localparam int NUM_CH = 16, NUM_TRIG = 4, PERIPH_N = 40, CH_W = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [CH_W-1:0] cfg_wr_ch = '0;
  logic [7:0] cfg_wdata = '0;
  logic [CH_W-1:0] cfg_rd_ch = '0;
  logic [7:0] cfg_rdata;
  logic [PERIPH_N-1:0] periph_req = '0;
  logic [NUM_TRIG-1:0] trig_pulse = '0;
  logic [NUM_CH-1:0] ch_ack = '0;
  logic [NUM_CH-1:0] ch_req;

  int n_tests = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  dma_req_router dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wr_ch(cfg_wr_ch),
    .cfg_wdata(cfg_wdata), .cfg_rd_ch(cfg_rd_ch), .cfg_rdata(cfg_rdata),
    .periph_req(periph_req), .trig_pulse(trig_pulse), .ch_ack(ch_ack),
    .ch_req(ch_req)
  );

  task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input int ch, input logic [7:0] d);
    cfg_we = 1'b1; cfg_wr_ch = CH_W'(ch); cfg_wdata = d;
    step();
    cfg_we = 1'b0;
  endtask

  task automatic clear_all();
    periph_req = '0; trig_pulse = '0; ch_ack = '0;
    for (int c = 0; c < NUM_CH; c++) wr(c, 8'h00);
    step();
  endtask

  task automatic t_reset();
    cfg_rd_ch = '0;
    check("R1 req", 32'(ch_req), 32'h0);
    check("R1 rdata", 32'(cfg_rdata), 32'h0);
    cfg_rd_ch = 4'd3; step();
    check("R1 rdata ch3", 32'(cfg_rdata), 32'h0);
  endtask

  task automatic t_readback();
    clear_all();
    cfg_rd_ch = 4'd2; wr(2, 8'hC9);
    check("R2 readback", 32'(cfg_rdata), 32'hC9);
    cfg_rd_ch = 4'd5; wr(5, 8'hC7);
    check("R3 trig bit reads 0", 32'(cfg_rdata), 32'h87);
    periph_req[6] = 1'b1; step();
    check("R3 trig bit no effect", 32'(ch_req[5]), 32'h1);
  endtask

  task automatic t_route();
    clear_all();
    wr(2, 8'h80 | 8'd10);
    periph_req[9] = 1'b1;
    check("R4 latency before edge", 32'(ch_req), 32'h0);
    step();
    check("R4 route src10", 32'(ch_req), 32'h0004);
    periph_req = '0; wr(3, 8'h80 | 8'd40);
    periph_req[39] = 1'b1; step();
    check("R4 route src40", 32'(ch_req), 32'h0008);
    periph_req = '0; step();
    check("R4 follows drop", 32'(ch_req), 32'h0);
  endtask

  task automatic t_dead();
    clear_all();
    wr(6, 8'h80); wr(7, 8'h80 | 8'd41); wr(11, 8'h80 | 8'd57);
    periph_req = '1; step(); step();
    check("R5 dead sources", 32'(ch_req), 32'h0);
  endtask

  task automatic t_always_disable();
    clear_all();
    wr(8, 8'h80 | 8'd58);
    check("R6 rises at write edge", 32'(ch_req), 32'h0100);
    wr(9, 8'h80 | 8'd63);
    for (int k = 0; k < 3; k++) begin
      step();
      check("R6 continuous", 32'(ch_req), 32'h0300);
    end
    wr(8, 8'd58);
    check("R7 drop at write edge", 32'(ch_req), 32'h0200);
  endtask

  task automatic t_conflict();
    clear_all();
    wr(10, 8'h80 | 8'd20); wr(12, 8'h80 | 8'd20);
    periph_req[19] = 1'b1; step();
    check("R11 lowest wins", 32'(ch_req), 32'h0400);
    wr(10, 8'd20);
    check("R11 handover", 32'(ch_req), 32'h1000);
  endtask

  task automatic t_paced();
    clear_all();
    wr(0, 8'hC0 | 8'd16); wr(1, 8'hC0 | 8'd15);
    periph_req[14] = 1'b1; periph_req[15] = 1'b1;
    repeat (3) step();
    check("R9 no pulse no req", 32'(ch_req), 32'h0);
    trig_pulse = 4'b0010; step(); trig_pulse = '0;
    check("R12 pulse1 arms ch1 only", 32'(ch_req), 32'h0002);
    step(); step();
    check("R8 held until ack", 32'(ch_req), 32'h0002);
    ch_ack[1] = 1'b1; step(); ch_ack = '0;
    check("R8 drop after ack", 32'(ch_req), 32'h0);
    step(); step();
    check("R8 waits for pulse", 32'(ch_req), 32'h0);
    trig_pulse = 4'b0001; step(); trig_pulse = '0;
    check("R12 pulse0 arms ch0 only", 32'(ch_req), 32'h0001);
  endtask

  task automatic t_discard();
    clear_all();
    wr(1, 8'hC0 | 8'd15);
    periph_req[14] = 1'b1;
    trig_pulse = 4'b0010; step(); trig_pulse = '0;
    check("R8 armed", 32'(ch_req), 32'h0002);
    wr(1, 8'h40 | 8'd15);
    check("R7 paced drop", 32'(ch_req), 32'h0);
    wr(1, 8'hC0 | 8'd15);
    step(); step();
    check("R10 discarded", 32'(ch_req), 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step();
    t_reset();
    t_readback();
    t_route();
    t_dead();
    t_always_disable();
    t_conflict();
    t_paced();
    t_discard();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule